// File: doc/BRIEF.md
# Cache Invalidation and Low-Region Cacheability Controller

This block sits beside the on-chip cache of a 386-class processor. It decides when the cache tag array must drop its contents, and it decides whether each access may be cached. Software configures it through two I/O ports. A write to the index port picks a register. The next access to the data port reads or writes that register. There is one control byte, found at index C0h.

Two events start an invalidation. The first is a rising edge on the bus-hold request from another bus master, such as a DMA engine. When the hold-flush enable bit is set, this edge clears every valid bit in one cycle. The second is any change on the A20 mask input. The block first passes this input through a synchronizer. It then walks the tag array one entry per clock. During the walk it invalidates only the entries whose tags map into the low 64 KiB of a 1 MiB block, which means address bits [19:16] are zero.

A second control bit makes that same low region non-cacheable, so software can avoid the flush altogether. While A20 masking is active, the block forces address bit 20 of the memory-side address to zero. Addresses just above 1 MiB then wrap into the low 64 KiB.

The flush sequencer is a three-state machine:
- ST_IDLE moves to ST_FULL on an enabled hold edge.
- ST_IDLE moves to ST_SCAN on an A20 change.
- ST_SCAN returns to ST_IDLE after the last entry.
- ST_SCAN restarts at entry 0 on a new A20 change.
- ST_SCAN moves to ST_FULL on an enabled hold edge.
- ST_FULL always returns to ST_IDLE after one cycle. An A20 change seen in that cycle is dropped, because the full clear already covers it.

Top module: `cache_guard`

## Requirements
- R1: After reset, the control byte reads 00h, `flush_busy` and `flush_all` are low, and every access is cacheable.
- R2: A value written to the index port (22h) stays valid for exactly one later access (read or write) to the data port (23h). A second data-port access without a new index behaves as an unknown index.
- R3: Index C0h selects the 8-bit control byte. A data-port write stores all 8 bits, and a data-port read returns them.
- R4: A data-port access with an index other than C0h, or with no valid index, reads FFh and leaves the control byte unchanged.
- R5: When control bit 5 is set and `hold_req` rises, `flush_all` is high for exactly one cycle. That cycle is the cycle after the one in which the rise is first sampled.
- R6: When control bit 5 is clear, a rise of `hold_req` produces no `flush_all`.
- R7: A change on `a20_mask_in` in either direction makes `flush_busy` go high on the third clock edge after the change. `tag_idx` then steps 0, 1, … up to N-1, one entry per cycle, and `flush_busy` falls after entry N-1.
- R8: During the walk, `tag_inv` is asserted only for entries whose stored tag corresponds to address bits [19:16] equal to zero. Other entries stay valid.
- R9: An enabled hold flush during a walk ends the walk. `flush_busy` is low in the cycle in which `flush_all` is high.
- R10: When control bit 0 is set, an access with address bits [19:16] equal to zero has `acc_cacheable` low. Other addresses stay cacheable. When bit 0 is clear, all addresses are cacheable.
- R11: While the synchronized A20 mask is high, `mem_addr` equals `acc_addr` with bit 20 forced to 0. While it is low, `mem_addr` equals `acc_addr`.
- R12: An A20 change during a walk restarts the walk at entry 0, on the third clock edge after the change, with `flush_busy` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid in the cycle of `io_rd` |
| hold_req | input | 1 | Bus-hold request from another bus master |
| a20_mask_in | input | 1 | Asynchronous A20 mask; 1 forces address bit 20 low |
| acc_addr | input | 32 | Physical address of the current access |
| acc_cacheable | output | 1 | 1 when the access may be cached |
| mem_addr | output | 32 | Memory-side address after A20 masking |
| tag_idx | output | 4 | Tag array entry addressed by the walk |
| tag_rd_data | input | 24 | Stored tag of entry `tag_idx` |
| tag_inv | output | 1 | Invalidate entry `tag_idx` this cycle |
| flush_all | output | 1 | Clear every valid bit this cycle |
| flush_busy | output | 1 | Selective walk in progress |

## Verification
The bench tracks the index lifetime. A design that kept the index for more than one data access would return the control byte where FFh is expected. A design that wrote under an unknown index would corrupt the byte that the bench reads back later.

The A20 path is checked at exact cycles. An extra or missing synchronizer stage moves the first `flush_busy` cycle. An off-by-one end test shortens or lengthens the walk. A bad region decode clears the wrong half of the bench's tag model.

A walk interrupted by a second A20 change must restart at entry 0. A walk hit by a hold edge must stop, with all valid bits cleared. With bit 5 clear, a hold edge must do nothing.

// File: rtl/cache_guard_pkg.sv
package cache_guard_pkg;

    // address bits that define the low 64 KiB of each 1 MiB block
    localparam int REGION_LO = 16;
    localparam int REGION_HI = 19;
    // address bit forced low while the A20 mask is active
    localparam int WRAP_BIT  = 20;

    // control byte field positions
    localparam int CTL_NOCACHE_LOW = 0;
    localparam int CTL_FLUSH_HOLD  = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FULL = 2'd2
    } flush_st_e;

endpackage

// File: rtl/cg_regif.sv
module cg_regif #(
    parameter int          IO_W       = 16,
    parameter logic [15:0] INDEX_PORT = 16'h0022,
    parameter logic [15:0] DATA_PORT  = 16'h0023,
    parameter logic [7:0]  CTRL_INDEX = 8'hC0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output logic [7:0]      ctl_q
);

    logic [7:0] idx_q;
    logic       idx_vld;
    logic       hit_index;
    logic       hit_data;
    logic       sel_ctl;

    assign hit_index = (io_addr == IO_W'(INDEX_PORT));
    assign hit_data  = (io_addr == IO_W'(DATA_PORT));
    assign sel_ctl   = idx_vld && (idx_q == CTRL_INDEX);

    // index is consumed by the first data-port access after it is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            idx_vld <= 1'b0;
            ctl_q   <= 8'h00;
        end else begin
            if (io_wr && hit_index) begin
                idx_q   <= io_wdata;
                idx_vld <= 1'b1;
            end else if ((io_wr || io_rd) && hit_data) begin
                idx_vld <= 1'b0;
            end
            if (io_wr && hit_data && sel_ctl) begin
                ctl_q <= io_wdata;
            end
        end
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && hit_data && sel_ctl) begin
            io_rdata = ctl_q;
        end
    end

endmodule

// File: rtl/cg_sync_edge.sv
module cg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic level,
    output logic toggle
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // last synchronizer stage and one history stage
    assign level  = chain[STAGES-1];
    assign toggle = chain[STAGES-1] ^ chain[STAGES];

endmodule

// File: rtl/cg_flush_fsm.sv
module cg_flush_fsm
    import cache_guard_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 24,
    parameter int TAG_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_req,
    input  logic             flush_on_hold,
    input  logic             a20_toggle,
    input  logic [TAG_W-1:0] tag_rd_data,
    output logic [IDX_W-1:0] tag_idx,
    output logic             tag_inv,
    output logic             flush_all,
    output logic             flush_busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
    localparam int RG_HI = REGION_HI - TAG_LSB;
    localparam int RG_LO = REGION_LO - TAG_LSB;

    flush_st_e        state, state_d;
    logic [IDX_W-1:0] scan_idx;
    logic             hold_q;
    logic             full_req;
    logic             scan_start;
    logic             tag_low;

    assign full_req   = hold_req && !hold_q && flush_on_hold;
    assign scan_start = (state_d == ST_SCAN) && ((state != ST_SCAN) || a20_toggle);
    assign tag_low    = (tag_rd_data[RG_HI:RG_LO] == '0);

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (full_req)        state_d = ST_FULL;
                else if (a20_toggle) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (full_req)                  state_d = ST_FULL;
                else if (a20_toggle)           state_d = ST_SCAN;
                else if (scan_idx == LAST_IDX) state_d = ST_IDLE;
            end
            ST_FULL: begin
                // an A20 change in this cycle is covered by the full clear
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            hold_q   <= 1'b0;
        end else begin
            state  <= state_d;
            hold_q <= hold_req;
            if (scan_start)              scan_idx <= '0;
            else if (state == ST_SCAN)   scan_idx <= scan_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tag_idx    = scan_idx;
        tag_inv    = 1'b0;
        flush_all  = 1'b0;
        flush_busy = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SCAN: begin
                flush_busy = 1'b1;
                tag_inv    = tag_low;
            end
            ST_FULL: flush_all = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cg_region.sv
module cg_region
    import cache_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              nocache_low,
    input  logic              a20_masked,
    output logic              acc_cacheable,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [ADDR_W-1:0] WRAP_MASK = ~(ADDR_W'(1) << WRAP_BIT);

    logic in_low;

    assign in_low        = (acc_addr[REGION_HI:REGION_LO] == '0);
    assign acc_cacheable = !(nocache_low && in_low);
    assign mem_addr      = a20_masked ? (acc_addr & WRAP_MASK) : acc_addr;

endmodule

// File: rtl/cache_guard.sv
module cache_guard
    import cache_guard_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          IO_W       = 16,
    parameter int          OFS_W      = 4,
    parameter int          IDX_W      = 4,
    parameter int          SYNC_STG   = 2,
    parameter logic [15:0] INDEX_PORT = 16'h0022,
    parameter logic [15:0] DATA_PORT  = 16'h0023,
    parameter logic [7:0]  CTRL_INDEX = 8'hC0,
    localparam int         TAG_LSB    = OFS_W + IDX_W,
    localparam int         TAG_W      = ADDR_W - TAG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_W-1:0]   io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              hold_req,
    input  logic              a20_mask_in,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_cacheable,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  tag_idx,
    input  logic [TAG_W-1:0]  tag_rd_data,
    output logic              tag_inv,
    output logic              flush_all,
    output logic              flush_busy
);

    logic [7:0] ctl_q;
    logic       a20_masked;
    logic       a20_toggle;

    cg_regif #(
        .IO_W       (IO_W),
        .INDEX_PORT (INDEX_PORT),
        .DATA_PORT  (DATA_PORT),
        .CTRL_INDEX (CTRL_INDEX)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .ctl_q    (ctl_q)
    );

    cg_sync_edge #(
        .STAGES (SYNC_STG)
    ) u_a20_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (a20_mask_in),
        .level   (a20_masked),
        .toggle  (a20_toggle)
    );

    cg_flush_fsm #(
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .TAG_LSB (TAG_LSB)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_req      (hold_req),
        .flush_on_hold (ctl_q[CTL_FLUSH_HOLD]),
        .a20_toggle    (a20_toggle),
        .tag_rd_data   (tag_rd_data),
        .tag_idx       (tag_idx),
        .tag_inv       (tag_inv),
        .flush_all     (flush_all),
        .flush_busy    (flush_busy)
    );

    cg_region #(
        .ADDR_W (ADDR_W)
    ) u_region (
        .acc_addr      (acc_addr),
        .nocache_low   (ctl_q[CTL_NOCACHE_LOW]),
        .a20_masked    (a20_masked),
        .acc_cacheable (acc_cacheable),
        .mem_addr      (mem_addr)
    );

endmodule

// File: rtl/cache_guard_chk.sv
module cache_guard_chk
    import cache_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 24,
    parameter int TAG_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_req,
    input logic              flush_all,
    input logic              flush_busy,
    input logic              tag_inv,
    input logic [TAG_W-1:0]  tag_rd_data,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_cacheable,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        ctl_q,
    input logic              a20_masked
);

    localparam int RG_HI = REGION_HI - TAG_LSB;
    localparam int RG_LO = REGION_LO - TAG_LSB;

    p_full_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !flush_all);

    p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_req) && ctl_q[CTL_FLUSH_HOLD]) |=> flush_all);

    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_req) && !ctl_q[CTL_FLUSH_HOLD]) |=> !flush_all);

    p_inv_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_inv |-> (flush_busy && (tag_rd_data[RG_HI:RG_LO] == '0)));

    p_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> !flush_busy);

    p_nocache_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CTL_NOCACHE_LOW] && (acc_addr[REGION_HI:REGION_LO] == '0)) |-> !acc_cacheable);

    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        a20_masked |-> (!mem_addr[WRAP_BIT] && (mem_addr[WRAP_BIT-1:0] == acc_addr[WRAP_BIT-1:0])));

endmodule

bind cache_guard cache_guard_chk #(
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W),
    .TAG_LSB (TAG_LSB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_req      (hold_req),
    .flush_all     (flush_all),
    .flush_busy    (flush_busy),
    .tag_inv       (tag_inv),
    .tag_rd_data   (tag_rd_data),
    .acc_addr      (acc_addr),
    .acc_cacheable (acc_cacheable),
    .mem_addr      (mem_addr),
    .ctl_q         (ctl_q),
    .a20_masked    (a20_masked)
);

// File: tb/cache_guard_tb.sv
`timescale 1ns/1ps
module cache_guard_tb;

    localparam int IDX_W = 4;
    localparam int NSETS = 1 << IDX_W;
    localparam int TAG_W = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [15:0]       io_addr;
    logic              io_wr, io_rd;
    logic [7:0]        io_wdata, io_rdata;
    logic              hold_req, a20_mask_in;
    logic [31:0]       acc_addr, mem_addr;
    logic              acc_cacheable;
    logic [IDX_W-1:0]  tag_idx;
    logic [TAG_W-1:0]  tag_rd_data;
    logic              tag_inv, flush_all, flush_busy;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [TAG_W-1:0] tmem [NSETS];
    logic [NSETS-1:0] vld;
    logic             reload;

    always #4 clk = ~clk;

    cache_guard u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hold_req(hold_req),
        .a20_mask_in(a20_mask_in), .acc_addr(acc_addr), .acc_cacheable(acc_cacheable),
        .mem_addr(mem_addr), .tag_idx(tag_idx), .tag_rd_data(tag_rd_data),
        .tag_inv(tag_inv), .flush_all(flush_all), .flush_busy(flush_busy)
    );

    // tag array model: even entries hold low-region tags (address bits 19:16 zero)
    initial begin
        for (int i = 0; i < NSETS; i++)
            tmem[i] = (TAG_W'(i) << 12) | ((i % 2 == 0) ? 24'h000040 : 24'h000340);
    end
    assign tag_rd_data = tmem[tag_idx];

    always @(posedge clk) begin
        if (reload)         vld <= '1;
        else if (flush_all) vld <= '0;
        else if (tag_inv)   vld[tag_idx] <= 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for read data
    always begin
        @(negedge clk);
        #1;
        if (io_rd) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard", 32'h1, 32'h0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, {24'h0, io_rdata}, {24'h0, e});
            end
        end
    end

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        io_write(16'h0022, 8'hC0);
        io_write(16'h0023, v);
    endtask

    task automatic do_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && flush_busy; k++) @(negedge clk);
    endtask

    function automatic logic [NSETS-1:0] odd_mask();
        logic [NSETS-1:0] m = '0;
        for (int i = 0; i < NSETS; i++) m[i] = (i % 2 == 1);
        return m;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
        hold_req = 0; a20_mask_in = 0; acc_addr = 32'h0000_0100; reload = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 busy", flush_busy, 0);
        chk("R1 flush_all", flush_all, 0);
        chk("R1 cacheable", acc_cacheable, 1);
        io_write(16'h0022, 8'hC0);
        io_read(16'h0023, 8'h00, "R1 ctl reset");

        // R3 full byte write/read
        set_ctl(8'hA5);
        io_write(16'h0022, 8'hC0);
        io_read(16'h0023, 8'hA5, "R3 ctl readback");
        // R2 index consumed by one access
        io_read(16'h0023, 8'hFF, "R2 stale index read");
        // R4 writes without valid index / with unknown index ignored
        io_write(16'h0023, 8'h11);
        io_write(16'h0022, 8'hC1);
        io_read(16'h0023, 8'hFF, "R4 unknown index read");
        io_write(16'h0022, 8'hC1);
        io_write(16'h0023, 8'h33);
        io_write(16'h0022, 8'hC0);
        io_read(16'h0023, 8'hA5, "R4 ctl unchanged");

        // R6 hold with bit 5 clear
        set_ctl(8'h00);
        do_reload();
        @(negedge clk); hold_req = 1'b1;
        @(negedge clk); #1; chk("R6 no flush c1", flush_all, 0);
        @(negedge clk); #1; chk("R6 no flush c2", flush_all, 0);
        chk("R6 valid kept", vld, {NSETS{1'b1}});
        hold_req = 1'b0;

        // R5 hold with bit 5 set
        set_ctl(8'h20);
        @(negedge clk); hold_req = 1'b1;
        @(negedge clk); #1; chk("R5 flush pulse", flush_all, 1);
        @(negedge clk); #1; chk("R5 pulse ends", flush_all, 0);
        chk("R5 all cleared", vld, 0);
        hold_req = 1'b0;

        // R7/R8 selective walk on A20 rising
        do_reload();
        @(negedge clk); a20_mask_in = 1'b1;
        repeat (2) @(negedge clk); #1; chk("R7 not yet busy", flush_busy, 0);
        @(negedge clk); #1;
        chk("R7 busy start", flush_busy, 1);
        chk("R7 first idx", tag_idx, 0);
        repeat (NSETS - 1) @(negedge clk); #1;
        chk("R7 still busy at last", flush_busy, 1);
        chk("R7 last idx", tag_idx, NSETS - 1);
        @(negedge clk); #1;
        chk("R7 busy ends", flush_busy, 0);
        chk("R8 only low tags cleared", vld, odd_mask());

        // R11 wrap while masked
        acc_addr = 32'h0010_FFF0; #1;
        chk("R11 wrap low", mem_addr, 32'h0000_FFF0);
        acc_addr = 32'h0031_2345; #1;
        chk("R11 wrap high", mem_addr, 32'h0021_2345);

        // R12 restart on falling then rising change
        do_reload();
        @(negedge clk); a20_mask_in = 1'b0;
        repeat (3) @(negedge clk); #1;
        chk("R7 falling edge starts walk", flush_busy, 1);
        repeat (5) @(negedge clk); #1;
        chk("R12 mid walk idx", tag_idx, 5);
        a20_mask_in = 1'b1;
        repeat (3) @(negedge clk); #1;
        chk("R12 restart idx", tag_idx, 0);
        chk("R12 busy held", flush_busy, 1);
        repeat (NSETS) @(negedge clk); #1;
        chk("R12 restarted walk ends", flush_busy, 0);

        // R9 hold preempts a walk
        do_reload();
        @(negedge clk); a20_mask_in = 1'b0;
        repeat (3 + 4) @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk); #1;
        chk("R9 flush_all", flush_all, 1);
        chk("R9 busy dropped", flush_busy, 0);
        @(negedge clk); #1;
        chk("R9 stays idle", flush_busy, 0);
        chk("R9 all cleared", vld, 0);
        hold_req = 1'b0;
        wait_idle();

        // R11 pass-through when unmasked
        acc_addr = 32'h0010_FFF0; #1;
        chk("R11 no wrap", mem_addr, 32'h0010_FFF0);

        // R10 non-cacheable low region
        set_ctl(8'h01);
        acc_addr = 32'h0020_8000; #1;
        chk("R10 low region uncached", acc_cacheable, 0);
        acc_addr = 32'h0021_0000; #1;
        chk("R10 other cached", acc_cacheable, 1);
        set_ctl(8'h00);
        acc_addr = 32'h0020_8000; #1;
        chk("R10 disabled", acc_cacheable, 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule